// File: doc/BRIEF.md
# Configurable Sample Demultiplexer

This block accepts one 10-bit sample per clock, together with an out-of-range flag, and spreads consecutive samples over four parallel output ports, A to D. It can also use only ports A and B. It drives a data-ready strobe that toggles each time a complete output word has been assembled. In a second mode the strobe toggles only on every other word. The block sits behind a fast converter core and presents its stream to slower downstream logic as wide words.

Control inputs choose the fan-out (two or four ports) and how the ports update. In simultaneous mode all ports change on one edge. In staggered mode each port changes on the edge that takes its own sample. An active-low self-test input replaces the incoming samples with an internal counter. An active-low sleep input forces every output to zero and freezes the block. A synchronous data-ready reset realigns the port sequence, the test counter and the strobe. An asynchronous reset puts the block into the same cleared state.

A two-state controller governs operation. In ST_RUN the block is active. In ST_SLEEP the outputs are blanked. Three transitions exist. ST_RUN goes to ST_SLEEP when the sleep input is low at an edge. ST_SLEEP goes to ST_RUN when the data-ready reset is high while the sleep input is high. A data-ready reset taken while the sleep input is low keeps or sends the block to ST_SLEEP.

Top module: `sample_demux`

## Requirements
- R1: With quad_sel=1 the block uses four ports in phases 0..3. With quad_sel=0 it uses ports A and B in phases 0..1, and port_c, port_d and their flag bits (port_ovr bits 2 and 3) read zero.
- R2: After any reset, the sample taken on the first active edge goes to port A, the next to B, then to C and D (in four-port mode), and the sequence then starts again at A.
- R3: With stagg_n=1 (simultaneous), every port changes together on the edge that takes the last sample of a word, and each port then shows the sample of its own phase in that word. On every other edge the ports hold.
- R4: With stagg_n=0 (staggered), a port updates on the edge that takes a sample of its own phase. The other ports hold on that edge.
- R5: With half_dr=0, dr_out toggles on each edge that completes a word and holds on all other edges.
- R6: With half_dr=1, dr_out toggles on every second word-completing edge counted from reset, so the first toggle comes after two words.
- R7: With bist_n=0, the sample is a 10-bit counter with a clear flag and in_data is ignored. The counter is 0 on the first active edge after reset, advances by one per active edge and wraps at 1024.
- R8: When sleep_n is low at an edge in ST_RUN, the block enters ST_SLEEP. In ST_SLEEP all port outputs, flags and dr_out read zero, and the phase and test counter do not advance.
- R9: Raising sleep_n alone does not leave ST_SLEEP. Only dr_rst=1 with sleep_n=1 returns the block to ST_RUN.
- R10: dr_rst=1 at an edge clears the ports, the phase, the test counter and dr_out to zero, whatever the other inputs are.
- R11: rst_n low clears the block asynchronously to the same state, in ST_RUN.
- R12: A sample's out-of-range flag appears on port_ovr at the bit of its port (A=bit 0 .. D=bit 3) at the same time as its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dr_rst | input | 1 | Synchronous data-ready reset and realign |
| in_data | input | 10 | Incoming sample |
| in_ovr | input | 1 | Out-of-range flag of the sample |
| quad_sel | input | 1 | 1: four ports, 0: two ports |
| stagg_n | input | 1 | 0: staggered updates, 1: simultaneous |
| half_dr | input | 1 | 1: strobe at half the word rate |
| bist_n | input | 1 | 0: self-test counter replaces samples |
| sleep_n | input | 1 | 0: enter sleep |
| port_a | output | 10 | Port A data |
| port_b | output | 10 | Port B data |
| port_c | output | 10 | Port C data |
| port_d | output | 10 | Port D data |
| port_ovr | output | 4 | Out-of-range flags, bit 0 = A .. bit 3 = D |
| dr_out | output | 1 | Data-ready strobe |

## Verification
The hardest case to reach is leaving sleep. The block has to enter ST_SLEEP while part of a word is in flight. It then has to stay there after sleep_n is released. Finally it must resume from a clean phase 0 only when dr_rst arrives. The stimulus drops sleep_n in the middle of a four-port word. It keeps sleep_n high without dr_rst for several cycles and watches that the outputs stay at zero. It then pulses dr_rst and runs the self-test counter, so the port order and the restart value after waking can be read directly from the ports.

// File: rtl/sdmx_pkg.sv
package sdmx_pkg;
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } dmx_state_e;
endpackage

// File: rtl/sdmx_seq.sv
module sdmx_seq
    import sdmx_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int DW    = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dr_rst,
    input  logic            sleep_n,
    input  logic            quad,
    output dmx_state_e      state,
    output logic            adv,
    output logic            last,
    output logic [$clog2(NPORT)-1:0] phase,
    output logic [DW-1:0]   bist_val
);
    localparam int PW = $clog2(NPORT);
    localparam logic [PW-1:0] LAST_FULL = PW'(NPORT - 1);
    localparam logic [PW-1:0] LAST_HALF = PW'(NPORT / 2 - 1);

    dmx_state_e state_nx;
    logic [PW-1:0] last_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        adv      = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (dr_rst)        state_nx = sleep_n ? ST_RUN : ST_SLEEP;
                else if (!sleep_n) state_nx = ST_SLEEP;
                else               adv = 1'b1;
            end
            ST_SLEEP: begin
                if (dr_rst && sleep_n) state_nx = ST_RUN;
            end
            default: state_nx = ST_RUN;
        endcase
    end

    assign last_idx = quad ? LAST_FULL : LAST_HALF;
    assign last     = (phase == last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= '0;
            bist_val <= '0;
        end else if (dr_rst) begin
            phase    <= '0;
            bist_val <= '0;
        end else if (adv) begin
            phase    <= last ? '0 : phase + 1'b1;
            bist_val <= bist_val + 1'b1;
        end
    end

    // R8 / R9: sleeping freezes the sequence until a data-ready reset
    p_sleep_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !dr_rst) |=> ($stable(phase) && $stable(bist_val) && state == ST_SLEEP));

    // R10: data-ready reset realigns the sequence
    p_drst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dr_rst |=> (phase == '0 && bist_val == '0));
endmodule

// File: rtl/sdmx_lanes.sv
module sdmx_lanes #(
    parameter int NPORT = 4,
    parameter int DW    = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      adv,
    input  logic                      last,
    input  logic                      stagg,
    input  logic [$clog2(NPORT)-1:0]  phase,
    input  logic [DW:0]               src,
    output logic [NPORT-1:0][DW:0]    q
);
    localparam int PW = $clog2(NPORT);

    logic [NPORT-1:0][DW:0] stage;

    for (genvar p = 0; p < NPORT; p++) begin : g_lane
        localparam logic [PW-1:0] MY_PH = PW'(p);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[p]     <= '0;
                stage[p] <= '0;
            end else if (clr) begin
                q[p]     <= '0;
                stage[p] <= '0;
            end else if (adv) begin
                if (stagg) begin
                    if (phase == MY_PH) q[p] <= src;
                end else if (last) begin
                    q[p] <= (phase == MY_PH) ? src : stage[p];
                end else if (phase == MY_PH) begin
                    stage[p] <= src;
                end
            end
        end

        // R4: in staggered mode only the addressed port moves
        p_stagg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (adv && !clr && stagg && phase != MY_PH) |=> $stable(q[p]));
    end

    // R3: in simultaneous mode ports move only at word completion
    p_sim_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && !stagg && !last) |=> $stable(q));
endmodule

// File: rtl/sdmx_strobe.sv
module sdmx_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    input  logic last,
    input  logic half,
    output logic dr
);
    logic wpar;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr   <= 1'b0;
            wpar <= 1'b0;
        end else if (clr) begin
            dr   <= 1'b0;
            wpar <= 1'b0;
        end else if (adv && last) begin
            if (half) begin
                wpar <= ~wpar;
                if (wpar) dr <= ~dr;
            end else begin
                dr <= ~dr;
            end
        end
    end

    // R5: full-rate strobe toggles on each word completion
    p_dr_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && last && !half && !clr) |=> (dr != $past(dr)));

    // R5 / R6: no toggle away from word completion
    p_dr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(adv && last)) |=> $stable(dr));
endmodule

// File: rtl/sample_demux.sv
module sample_demux
    import sdmx_pkg::*;
#(
    parameter int DW    = 10,
    parameter int NPORT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dr_rst,
    input  logic [DW-1:0] in_data,
    input  logic          in_ovr,
    input  logic          quad_sel,
    input  logic          stagg_n,
    input  logic          half_dr,
    input  logic          bist_n,
    input  logic          sleep_n,
    output logic [DW-1:0] port_a,
    output logic [DW-1:0] port_b,
    output logic [DW-1:0] port_c,
    output logic [DW-1:0] port_d,
    output logic [3:0]    port_ovr,
    output logic          dr_out
);
    localparam int PW = $clog2(NPORT);

    dmx_state_e             state;
    logic                   adv, last, dr_q, awake;
    logic [PW-1:0]          phase;
    logic [DW-1:0]          bist_val;
    logic [DW:0]            src;
    logic [NPORT-1:0][DW:0] lanes;
    logic [NPORT-1:0][DW:0] shown;

    sdmx_seq #(.NPORT(NPORT), .DW(DW)) i_seq (
        .clk(clk), .rst_n(rst_n), .dr_rst(dr_rst), .sleep_n(sleep_n),
        .quad(quad_sel), .state(state), .adv(adv), .last(last),
        .phase(phase), .bist_val(bist_val)
    );

    assign src = bist_n ? {in_ovr, in_data} : {1'b0, bist_val};

    sdmx_lanes #(.NPORT(NPORT), .DW(DW)) i_lanes (
        .clk(clk), .rst_n(rst_n), .clr(dr_rst), .adv(adv), .last(last),
        .stagg(!stagg_n), .phase(phase), .src(src), .q(lanes)
    );

    sdmx_strobe i_strobe (
        .clk(clk), .rst_n(rst_n), .clr(dr_rst), .adv(adv), .last(last),
        .half(half_dr), .dr(dr_q)
    );

    assign awake = (state == ST_RUN);

    for (genvar p = 0; p < NPORT; p++) begin : g_show
        localparam bit UPPER = (p >= NPORT / 2);
        assign shown[p] = (awake && (!UPPER || quad_sel)) ? lanes[p] : '0;
    end

    assign port_a   = shown[0][DW-1:0];
    assign port_b   = shown[1][DW-1:0];
    assign port_c   = shown[2][DW-1:0];
    assign port_d   = shown[3][DW-1:0];
    assign port_ovr = {shown[3][DW], shown[2][DW], shown[1][DW], shown[0][DW]};
    assign dr_out   = awake & dr_q;
endmodule

// File: tb/test_sample_demux.sv
module test_sample_demux;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dr_rst = 1'b0;
    logic [9:0] in_data = '0;
    logic       in_ovr = 1'b0;
    logic       quad_sel = 1'b1;
    logic       stagg_n = 1'b1;
    logic       half_dr = 1'b0;
    logic       bist_n = 1'b1;
    logic       sleep_n = 1'b1;
    logic [9:0] port_a, port_b, port_c, port_d;
    logic [3:0] port_ovr;
    logic       dr_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R11";

    always #(CLK_PERIOD / 2) clk = ~clk;

    sample_demux i_sample_demux (
        .clk(clk), .rst_n(rst_n), .dr_rst(dr_rst), .in_data(in_data),
        .in_ovr(in_ovr), .quad_sel(quad_sel), .stagg_n(stagg_n),
        .half_dr(half_dr), .bist_n(bist_n), .sleep_n(sleep_n),
        .port_a(port_a), .port_b(port_b), .port_c(port_c), .port_d(port_d),
        .port_ovr(port_ovr), .dr_out(dr_out)
    );

    // behavioural reference: a queue collects the word in simultaneous mode
    int         mph;
    logic [9:0] mcnt;
    logic       mdr, mpar;
    bit         msleep;
    logic [10:0] mq [4];
    logic [10:0] word [$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || dr_rst) begin
            mph = 0; mcnt = '0; mdr = 0; mpar = 0;
            for (int p = 0; p < 4; p++) mq[p] = '0;
            word.delete();
            msleep = rst_n ? !sleep_n : 1'b0;
        end else if (msleep) begin
            // frozen
        end else if (!sleep_n) begin
            msleep = 1;
        end else begin
            int n;
            logic [10:0] s;
            n = quad_sel ? 4 : 2;
            s = bist_n ? {in_ovr, in_data} : {1'b0, mcnt};
            mcnt = mcnt + 1'b1;
            if (!stagg_n) mq[mph] = s;
            else begin
                word.push_back(s);
                if (mph == n - 1) begin
                    for (int p = 0; p < word.size(); p++) mq[p] = word[p];
                    word.delete();
                end
            end
            if (mph == n - 1) begin
                if (half_dr) begin
                    if (mpar) mdr = ~mdr;
                    mpar = ~mpar;
                end else mdr = ~mdr;
                mph = 0;
            end else mph++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] expect_port(input int p);
        if (msleep || (p >= 2 && !quad_sel)) return '0;
        return mq[p];
    endfunction

    task automatic compare_all();
        logic [9:0] act [4];
        act[0] = port_a; act[1] = port_b; act[2] = port_c; act[3] = port_d;
        for (int p = 0; p < 4; p++) begin
            logic [10:0] e;
            e = expect_port(p);
            check(act[p] == e[9:0], tag, $sformatf("port%0d data", p), act[p], e[9:0]);
            check(port_ovr[p] == e[10], tag, $sformatf("port%0d ovr (R12)", p), port_ovr[p], e[10]);
        end
        check(dr_out == (msleep ? 1'b0 : mdr), tag, "dr_out", dr_out, msleep ? 0 : mdr);
    endtask

    // one clock: inputs already set; compare at the falling edge
    task automatic tick();
        @(negedge clk);
        compare_all();
        in_data = 10'($urandom);
        in_ovr  = ($urandom % 5) == 0;
    endtask

    task automatic realign();
        dr_rst = 1'b1;
        tick();
        dr_rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R11: asynchronous reset state
        #(CLK_PERIOD * 2 + 2);
        tag = "R11";
        check(port_a == 0 && port_b == 0 && port_c == 0 && port_d == 0 && dr_out == 0,
              "R11", "reset outputs", {port_a, port_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R12: four ports, simultaneous, full-rate strobe
        tag = "R3";
        realign();
        for (int i = 0; i < 24; i++) tick();

        // R4: staggered
        tag = "R4";
        stagg_n = 1'b0;
        realign();
        for (int i = 0; i < 18; i++) tick();

        // R1 R6: two ports, half-rate strobe
        tag = "R6";
        stagg_n = 1'b1; quad_sel = 1'b0; half_dr = 1'b1;
        realign();
        tick(); tick();
        check(dr_out == 1'b0, "R6", "dr after one word", dr_out, 0);
        tick(); tick();
        check(dr_out == 1'b1, "R6", "dr after two words", dr_out, 1);
        check(port_c == 0 && port_d == 0, "R1", "C/D in two-port mode", port_c, 0);
        for (int i = 0; i < 12; i++) tick();

        // R7: self-test counter in four-port simultaneous mode
        tag = "R7";
        quad_sel = 1'b1; half_dr = 1'b0; bist_n = 1'b0;
        realign();
        for (int i = 0; i < 8; i++) tick();
        check(port_a == 4, "R7", "bist port A", port_a, 4);
        check(port_d == 7, "R7", "bist port D", port_d, 7);
        check(port_ovr == 0, "R7", "bist flags", port_ovr, 0);

        // R8: sleep in mid word
        tag = "R8";
        bist_n = 1'b1;
        tick(); tick();
        sleep_n = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        check(port_a == 0 && dr_out == 0, "R8", "sleep blanks", port_a, 0);

        // R9: release without realign stays asleep
        tag = "R9";
        sleep_n = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        check(port_b == 0, "R9", "still asleep", port_b, 0);
        bist_n = 1'b0;
        realign();
        for (int i = 0; i < 4; i++) tick();
        check(port_a == 0 && port_b == 1 && port_c == 2 && port_d == 3,
              "R9", "restart at phase 0", port_d, 3);

        // R10: realign mid run clears everything
        tag = "R10";
        bist_n = 1'b1; stagg_n = 1'b0;
        for (int i = 0; i < 7; i++) tick();
        realign();
        check(port_a == 0 && port_b == 0 && port_c == 0 && port_d == 0 && dr_out == 0,
              "R10", "cleared by realign", port_a, 0);
        for (int i = 0; i < 10; i++) tick();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule